// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 20-bit physical frame number. The page table it walks lives in memory and is itself split into pages: a directory, whose base the requester supplies with each request, holds entries that point at second-level tables. Those second-level tables hold the final frame numbers. Each translation therefore takes two dependent word reads. The address of the second read is only known once the first read returns.

The requester offers a virtual address and a directory base while the walker is idle. The walker then issues a one-cycle read request on its memory port and waits for the matching read-valid strobe, however many cycles that takes. It checks the valid bit of the returned entry and, if the entry is valid, moves on to the second level. It finishes with a single-cycle completion pulse that carries either a frame number or a fault. The 12-bit page offset is never translated and plays no part in the walk.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `done` and `mem_req` are 0.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from acceptance until the cycle after `done`, and a `req_valid` raised in that time has no effect on the memory reads or the result.
- R3: In the cycle after acceptance, `mem_req` is 1 and `mem_addr` equals `root + vaddr[31:22]*4`. The root must be a multiple of 4, so every read address has its two low bits at zero.
- R4: `mem_req` is high for exactly one cycle per read. The walker then waits any number of cycles (at least one) for `mem_rvalid`, and it ignores `mem_rvalid` whenever it is not waiting for a read.
- R5: A directory entry is valid when its bit 0 is 1. Bits 31:12 of a valid directory entry give the second-level table's frame. In the cycle after that entry arrives, the walker issues the second read at `{entry[31:12], 12'h000} + vaddr[21:12]*4`.
- R6: If the directory entry has bit 0 at 0, the walker issues no second read. In the cycle after the entry arrives, `done` is 1 with `fault` at 1.
- R7: If the second-level entry has bit 0 at 1, then in the cycle after it arrives `done` is 1, `fault` is 0 and `frame` equals entry bits 31:12.
- R8: If the second-level entry has bit 0 at 0, the completion carries `fault` at 1. Whenever `fault` is 1, `frame` is 0.
- R9: `done` lasts one cycle. `fault` is 1 only while `done` is 1. `req_ready` returns to 1 in the cycle after `done`.
- R10: Bits 11:0 of the virtual address affect neither the read addresses nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Byte address of the directory table (multiple of 4) |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | 32 | Byte address of the word to read |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | 32 | Returned table entry |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion is a fault (an invalid entry was found) |
| frame | output | 20 | Translated frame number, zero on a fault |

## Verification
Internal state shows up within one or two cycles at the memory port. A state register that skips or repeats a step shows as a missing, doubled or stretched `mem_req`, or as a second read after an invalid directory entry, seen on the first walk that takes that path. A wrong index slice or a wrong shift in address formation shows as a wrong `mem_addr` on the very read that uses it. Sweeping every directory index and every second-level index separately exposes a single miswired bit. A latched frame or fault that is stale or badly masked shows in the completion cycle as a mismatch against an entry that the bench computes from the read address itself.

// File: rtl/pt_walk_pkg.sv
// Shared types for the two-level page table walker.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package pt_walk_pkg;

    // Walk sequence; the order of the steps is the order of the reads.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_DIR  = 3'd1,
        ST_WT_DIR  = 3'd2,
        ST_RD_LEAF = 3'd3,
        ST_WT_LEAF = 3'd4,
        ST_FINISH  = 3'd5
    } walk_state_t;

endpackage

// File: rtl/pt_vpn_split.sv
// Splits a virtual page number into a directory index (upper bits) and a
// leaf-table index (lower bits).
// Assumes: VPN_W > LEAF_W > 0.
module pt_vpn_split #(
    parameter int VPN_W  = 20,
    parameter int LEAF_W = 10,
    localparam int DIR_W = VPN_W - LEAF_W
) (
    input  logic [VPN_W-1:0]  vpn,
    output logic [DIR_W-1:0]  dir_idx,
    output logic [LEAF_W-1:0] leaf_idx
);

    // Slice the page number into its two table indices.
    always_comb begin
        dir_idx  = vpn[VPN_W-1:LEAF_W];
        leaf_idx = vpn[LEAF_W-1:0];
    end

endmodule

// File: rtl/pt_entry_addr.sv
// Forms the byte address of a table entry: base + index * entry size.
// Assumes: entry size is a power of two, given as ENT_LOG2; the base is
// aligned to the entry size.
module pt_entry_addr #(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 10,
    parameter int ENT_LOG2 = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);

    // Scale the index to bytes and add it to the table base.
    always_comb begin
        addr = base + (ADDR_W'(idx) << ENT_LOG2);
    end

endmodule

// File: rtl/pt_walk_fsm.sv
// Sequencer for the walk: accept, read directory, wait, read leaf, wait,
// finish. It produces load strobes for the datapath in the top module.
// Assumes: memory returns exactly one mem_rvalid for each read request,
// no earlier than the cycle after the request.
module pt_walk_fsm
    import pt_walk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        mem_rvalid,
    input  logic        entry_ok,
    output walk_state_t state,
    output logic        ld_req,
    output logic        ld_dir,
    output logic        ld_leaf
);

    walk_state_t state_nx;

    // Next-state choice and the load strobes of the current step.
    always_comb begin
        state_nx = state;
        ld_req   = 1'b0;
        ld_dir   = 1'b0;
        ld_leaf  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    ld_req   = 1'b1;
                    state_nx = ST_RD_DIR;
                end
            end
            ST_RD_DIR:  state_nx = ST_WT_DIR;
            ST_WT_DIR: begin
                if (mem_rvalid) begin
                    ld_dir   = 1'b1;
                    state_nx = entry_ok ? ST_RD_LEAF : ST_FINISH;
                end
            end
            ST_RD_LEAF: state_nx = ST_WT_LEAF;
            ST_WT_LEAF: begin
                if (mem_rvalid) begin
                    ld_leaf  = 1'b1;
                    state_nx = ST_FINISH;
                end
            end
            ST_FINISH:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker. Takes a virtual address and a directory
// base, reads the directory entry, then (when valid) the leaf entry, and
// reports a frame number or a fault with a one-cycle done pulse.
// Assumes: the directory base is aligned to the entry size; entries carry
// a valid flag in bit 0 and a frame number in their upper bits.
module pt_walker #(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 12,
    parameter int LEAF_W   = 10,
    parameter int ENT_LOG2 = 2,
    localparam int VPN_W   = ADDR_W - OFF_W,
    localparam int DIR_W   = VPN_W - LEAF_W,
    localparam int FRAME_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_vaddr,
    input  logic [ADDR_W-1:0]  req_root,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [ADDR_W-1:0]  mem_rdata,
    output logic               done,
    output logic               fault,
    output logic [FRAME_W-1:0] frame
);
    import pt_walk_pkg::*;

    walk_state_t        state;
    logic               ld_req, ld_dir, ld_leaf;
    logic [VPN_W-1:0]   vpn_q;
    logic [ADDR_W-1:0]  root_q;
    logic [FRAME_W-1:0] leaf_tbl_q;
    logic [FRAME_W-1:0] frame_q;
    logic               fault_q;
    logic [DIR_W-1:0]   dir_idx;
    logic [LEAF_W-1:0]  leaf_idx;
    logic [ADDR_W-1:0]  dir_addr;
    logic [ADDR_W-1:0]  leaf_addr;
    logic [ADDR_W-1:0]  leaf_base;
    logic               entry_ok;

    assign entry_ok  = mem_rdata[0];
    assign leaf_base = {leaf_tbl_q, {OFF_W{1'b0}}};

    pt_walk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .mem_rvalid (mem_rvalid),
        .entry_ok   (entry_ok),
        .state      (state),
        .ld_req     (ld_req),
        .ld_dir     (ld_dir),
        .ld_leaf    (ld_leaf)
    );

    pt_vpn_split #(.VPN_W(VPN_W), .LEAF_W(LEAF_W)) u_split (
        .vpn      (vpn_q),
        .dir_idx  (dir_idx),
        .leaf_idx (leaf_idx)
    );

    pt_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(DIR_W), .ENT_LOG2(ENT_LOG2)) u_dir_addr (
        .base (root_q),
        .idx  (dir_idx),
        .addr (dir_addr)
    );

    pt_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(LEAF_W), .ENT_LOG2(ENT_LOG2)) u_leaf_addr (
        .base (leaf_base),
        .idx  (leaf_idx),
        .addr (leaf_addr)
    );

    // Latch the request: page number and directory base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            root_q <= '0;
        end else if (ld_req) begin
            vpn_q  <= req_vaddr[ADDR_W-1:OFF_W];
            root_q <= req_root;
        end
    end

    // Latch entry contents: leaf table frame, final frame and fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leaf_tbl_q <= '0;
            frame_q    <= '0;
            fault_q    <= 1'b0;
        end else if (ld_req) begin
            frame_q <= '0;
            fault_q <= 1'b0;
        end else if (ld_dir) begin
            leaf_tbl_q <= mem_rdata[ADDR_W-1:OFF_W];
            fault_q    <= !entry_ok;
        end else if (ld_leaf) begin
            frame_q <= entry_ok ? mem_rdata[ADDR_W-1:OFF_W] : '0;
            fault_q <= !entry_ok;
        end
    end

    // Drive the request port and the completion outputs from the state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        mem_req   = (state == ST_RD_DIR) || (state == ST_RD_LEAF);
        mem_addr  = (state == ST_RD_LEAF) ? leaf_addr : dir_addr;
        done      = (state == ST_FINISH);
        fault     = done && fault_q;
        frame     = (done && !fault_q) ? frame_q : '0;
    end

endmodule

// File: rtl/pt_walker_chk.sv
// Protocol checker for pt_walker; observes the ports only.
module pt_walker_chk #(
    parameter int ADDR_W  = 32,
    parameter int FRAME_W = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               mem_req,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               done,
    input logic               fault,
    input logic [FRAME_W-1:0] frame
);

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    a_r3_accept_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req && !req_ready));

    a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    a_r4_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r8_fault_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (frame == '0));

    a_r9_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .done      (done),
    .fault     (fault),
    .frame     (frame)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_root = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic        fault;
    logic [19:0] frame;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pt_walker uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .req_root   (req_root),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .fault      (fault),
        .frame      (frame)
    );

    // Memory contents as a function of the word address.
    function automatic logic [31:0] pte_of(input logic [31:0] a);
        logic [19:0] fr;
        logic        v;
        fr = a[21:2] ^ 20'hA5C3E ^ {a[31:22], 10'h0};
        v  = (a[4:2] != 3'b111);
        return {fr, 11'h0, v};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Answer one outstanding read after lat cycles; optionally poke a request.
    task automatic serve(input int lat, input logic [31:0] data, input bit poke,
                         input logic [31:0] va);
        for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            if (k == 0) chk("R4 mem_req single cycle", {31'b0, mem_req}, 32'd0);
            if (poke) begin
                req_valid = 1'b1;
                req_vaddr = ~va;
                req_root  = 32'h0BAD_0000;
                chk("R2 not ready while busy", {31'b0, req_ready}, 32'd0);
            end
        end
        req_valid  = 1'b0;
        mem_rvalid = 1'b1;
        mem_rdata  = data;
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = 32'hDEAD_BEEF;
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] root,
                        input int lat1, input int lat2, input bit poke);
        logic [31:0] a1, e1, a2, e2;
        a1 = root + {20'b0, va[31:22], 2'b00};
        e1 = pte_of(a1);
        a2 = {e1[31:12], 12'h000} + {20'b0, va[21:12], 2'b00};
        e2 = pte_of(a2);
        @(negedge clk);
        chk("R2 ready in idle", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        req_root  = root;
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = 32'h5555_5555;
        chk("R3 outer read issued", {31'b0, mem_req}, 32'd1);
        chk("R3 R10 outer address", mem_addr, a1);
        serve(lat1, e1, poke, va);
        if (!e1[0]) begin
            chk("R6 done after invalid outer", {31'b0, done}, 32'd1);
            chk("R6 fault on outer", {31'b0, fault}, 32'd1);
            chk("R6 no inner read", {31'b0, mem_req}, 32'd0);
            chk("R8 frame zero on fault", {12'b0, frame}, 32'd0);
        end else begin
            chk("R5 not done yet", {31'b0, done}, 32'd0);
            chk("R5 inner read issued", {31'b0, mem_req}, 32'd1);
            chk("R5 R10 inner address", mem_addr, a2);
            serve(lat2, e2, 1'b0, va);
            chk("R7 done after inner", {31'b0, done}, 32'd1);
            if (e2[0]) begin
                chk("R7 no fault", {31'b0, fault}, 32'd0);
                chk("R7 R10 frame", {12'b0, frame}, {12'b0, e2[31:12]});
            end else begin
                chk("R8 fault on inner", {31'b0, fault}, 32'd1);
                chk("R8 frame zero", {12'b0, frame}, 32'd0);
            end
        end
        @(negedge clk);
        chk("R9 done one cycle", {31'b0, done}, 32'd0);
        chk("R9 fault low after done", {31'b0, fault}, 32'd0);
        chk("R9 ready after done", {31'b0, req_ready}, 32'd1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);
        chk("R1 done low after reset", {31'b0, done}, 32'd0);
        chk("R1 no read after reset", {31'b0, mem_req}, 32'd0);

        // R4: a stray read-valid in idle does nothing.
        mem_rvalid = 1'b1;
        mem_rdata  = 32'hFFFF_F001;
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk("R4 stray rvalid no done", {31'b0, done}, 32'd0);
        chk("R4 stray rvalid no read", {31'b0, mem_req}, 32'd0);
        chk("R4 stray rvalid still ready", {31'b0, req_ready}, 32'd1);

        // Sweep every directory index with varied offsets, roots and latency.
        for (int i = 0; i < 1024; i++) begin
            logic [31:0] va, root;
            va   = {i[9:0], 10'((i * 37) % 1024), 12'((i * 331) % 4096)};
            root = 32'h0040_0000 + (i << 5);
            walk(va, root, 1 + (i % 4), 1 + ((i / 4) % 3), (i % 7) == 3);
        end

        // Sweep every leaf index under valid and invalid directory entries.
        for (int j = 0; j < 1024; j++) begin
            logic [31:0] va;
            va = {10'((j * 13) % 1024), j[9:0], 12'(4095 - j)};
            walk(va, 32'h1230_0000 + ((j % 8) << 2), 1 + (j % 3), 1 + (j % 5), 1'b0);
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule